// File: doc/BRIEF.md
# PLL Configuration Register Bank with Unlock Sequence

This block is the software-facing register bank for one PLL. Software writes a new multiplier, pre-divider and enable into pending (shadow) registers. None of these writes reaches the PLL controls until software writes an unlock key pair to a dedicated key register. The pair is 0xAA and then 0x55, with no other bus write between them. When the pair completes, every pending value is copied to the active controls in a single clock cycle.

The block drives the active multiplier, divider and enable to the PLL. It samples the PLL's lock indication into a status register, so software can poll it after enabling the PLL. A second status register shows an oscillator-ready input, which software polls after starting the main oscillator.

The key sequencer is a two-state machine. `KEY_IDLE` moves to `KEY_ARMED` on a key write of 0xAA (transition *arm*). `KEY_ARMED` moves back to `KEY_IDLE` on one of these events:
- a key write of 0x55, which commits the pending values (transition *commit*);
- a key write of any value other than 0xAA or 0x55 (transition *reject*);
- a write to any other address (transition *interrupt*).

A key write of 0xAA in `KEY_ARMED` keeps the state (transition *rearm*). Idle cycles and reads leave the state unchanged.

Top module: `pll_feed_regs`

## Requirements
- R1: After reset, the pending values, the active multiplier, divider and enable, and the lock flag are all zero, and the sequencer is in `KEY_IDLE`.
- R2: A write to CFG (word address 0: multiplier in bits [14:0], divider in bits [23:16]) or to CTRL (word address 1: enable in bit 0) updates only the pending value. A read of either register returns the pending value. The outputs `pll_mult_o`, `pll_div_o` and `pll_en_o` do not change.
- R3: A commit requires a write of exactly 32'h0000_00AA to KEY (word address 2) followed by a write of exactly 32'h0000_0055 to KEY. Idle cycles and reads between the two writes do not cancel the sequence.
- R4: A commit copies the pending multiplier, divider and enable to the outputs together. The outputs take the new values at the clock edge that samples the 0x55 write.
- R5: The armed state is cancelled by a write to any other address or by a key write of any other value, and the 0x55 that follows then commits nothing. A 0x55 that arrives without a preceding 0xAA has no effect.
- R6: A repeated 0xAA while armed keeps the sequence armed, so a following 0x55 commits.
- R7: The STAT register (word address 3) holds the active multiplier in bits [14:0], the active divider in bits [23:16], the active enable in bit 24 and the lock flag in bit 25. The lock flag is `pll_locked_i` registered once, and it is forced to 0 while the active enable is 0.
- R8: A commit that changes the multiplier or the divider clears the lock flag for the cycle after the commit, even when `pll_locked_i` is high.
- R9: The OSC register (word address 4) returns `osc_ready_i` in bit 0. KEY and unmapped addresses read as zero. `bus_rdata` is zero while `bus_re` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_re | input | 1 | Read strobe; read data is returned in the same cycle |
| bus_rdata | output | 32 | Read data |
| pll_locked_i | input | 1 | Lock indication from the PLL |
| osc_ready_i | input | 1 | Oscillator-ready indication |
| pll_mult_o | output | 15 | Active multiplier |
| pll_div_o | output | 8 | Active pre-divider |
| pll_en_o | output | 1 | Active PLL enable |

## Verification
The embedded assertions check, on every cycle, the following properties:
- the active values change only in the cycle after a commit, and then equal the pending values;
- an interrupting write always returns the sequencer to idle;
- the lock flag is never set while the enable is off;
- a commit that changes the multiplier or the divider drops the lock flag.

Only the bench scenarios can show the following:
- which exact write orders count as a commit (repeated 0xAA, reads between the keys, a rejected value, a 0x55 arriving alone);
- that pending values read back while the outputs hold still;
- the bit positions of the status and oscillator registers.

// File: rtl/pllfeed_pkg.sv
package pllfeed_pkg;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 3;
    localparam int MULT_W   = 15;
    localparam int DIV_W    = 8;
    localparam int DIV_LSB  = 16;
    localparam int EN_BIT   = 24;
    localparam int LOCK_BIT = 25;

    localparam logic [ADDR_W-1:0] A_CFG  = 3'd0;
    localparam logic [ADDR_W-1:0] A_CTRL = 3'd1;
    localparam logic [ADDR_W-1:0] A_KEY  = 3'd2;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd3;
    localparam logic [ADDR_W-1:0] A_OSC  = 3'd4;

    localparam logic [DATA_W-1:0] KEY_FIRST  = 32'h0000_00AA;
    localparam logic [DATA_W-1:0] KEY_SECOND = 32'h0000_0055;

    typedef enum logic {
        KEY_IDLE  = 1'b0,
        KEY_ARMED = 1'b1
    } key_state_t;
endpackage

// File: rtl/pllfeed_seq.sv
module pllfeed_seq
    import pllfeed_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_we,
    input  logic              other_we,
    input  logic [DATA_W-1:0] key_data,
    output logic              commit_o
);
    key_state_t state_q, state_d;

    logic is_first, is_second;
    assign is_first  = (key_data == KEY_FIRST);
    assign is_second = (key_data == KEY_SECOND);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            KEY_IDLE: begin
                if (key_we && is_first) state_d = KEY_ARMED;           // arm
            end
            KEY_ARMED: begin
                if (other_we)                         state_d = KEY_IDLE;  // interrupt
                else if (key_we && is_first)          state_d = KEY_ARMED; // rearm
                else if (key_we)                      state_d = KEY_IDLE;  // commit / reject
            end
            default: state_d = KEY_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= KEY_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        commit_o = 1'b0;
        unique case (state_q)
            KEY_IDLE:  commit_o = 1'b0;
            KEY_ARMED: commit_o = key_we && is_second;
            default:   commit_o = 1'b0;
        endcase
    end

    // R5: a write elsewhere while armed always cancels the sequence
    a_r5_interrupt_idles: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == KEY_ARMED && other_we) |=> (state_q == KEY_IDLE));
    // R3: a commit is only possible after an arming key write
    a_r3_commit_after_arm: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> (state_q == KEY_ARMED));
endmodule

// File: rtl/pllfeed_bank.sv
module pllfeed_bank
    import pllfeed_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              ctrl_we,
    input  logic [MULT_W-1:0] mult_in,
    input  logic [DIV_W-1:0]  div_in,
    input  logic              en_in,
    input  logic              commit_i,
    input  logic              pll_locked_i,
    output logic [MULT_W-1:0] sh_mult,
    output logic [DIV_W-1:0]  sh_div,
    output logic              sh_en,
    output logic [MULT_W-1:0] act_mult,
    output logic [DIV_W-1:0]  act_div,
    output logic              act_en,
    output logic              lock_q
);
    logic mn_change, en_next, lock_d;

    assign mn_change = commit_i && ((sh_mult != act_mult) || (sh_div != act_div));
    assign en_next   = commit_i ? sh_en : act_en;
    assign lock_d    = pll_locked_i && en_next && !mn_change;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_mult <= '0;
            sh_div  <= '0;
            sh_en   <= 1'b0;
        end else begin
            if (cfg_we) begin
                sh_mult <= mult_in;
                sh_div  <= div_in;
            end
            if (ctrl_we) sh_en <= en_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_mult <= '0;
            act_div  <= '0;
            act_en   <= 1'b0;
            lock_q   <= 1'b0;
        end else begin
            if (commit_i) begin
                act_mult <= sh_mult;
                act_div  <= sh_div;
                act_en   <= sh_en;
            end
            lock_q <= lock_d;
        end
    end

    // R4: a commit loads all pending values in one step
    a_r4_commit_copies: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |=> (act_mult == $past(sh_mult) && act_div == $past(sh_div)
                      && act_en == $past(sh_en)));
    // R2: active values move only as a result of a commit
    a_r2_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({act_mult, act_div, act_en}) |-> $past(commit_i));
    // R7: no lock while disabled
    a_r7_lock_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |-> act_en);
    // R8: changing the ratio drops lock
    a_r8_lock_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && (sh_mult != act_mult || sh_div != act_div)) |=> !lock_q);
endmodule

// File: rtl/pll_feed_regs.sv
module pll_feed_regs
    import pllfeed_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              pll_locked_i,
    input  logic              osc_ready_i,
    output logic [MULT_W-1:0] pll_mult_o,
    output logic [DIV_W-1:0]  pll_div_o,
    output logic              pll_en_o
);
    logic key_we, other_we, cfg_we, ctrl_we, commit;
    logic [MULT_W-1:0] sh_mult, act_mult;
    logic [DIV_W-1:0]  sh_div, act_div;
    logic sh_en, act_en, lock_q;

    assign key_we   = bus_we && (bus_addr == A_KEY);
    assign other_we = bus_we && (bus_addr != A_KEY);
    assign cfg_we   = bus_we && (bus_addr == A_CFG);
    assign ctrl_we  = bus_we && (bus_addr == A_CTRL);

    pllfeed_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_we   (key_we),
        .other_we (other_we),
        .key_data (bus_wdata),
        .commit_o (commit)
    );

    pllfeed_bank u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .ctrl_we      (ctrl_we),
        .mult_in      (bus_wdata[MULT_W-1:0]),
        .div_in       (bus_wdata[DIV_LSB +: DIV_W]),
        .en_in        (bus_wdata[0]),
        .commit_i     (commit),
        .pll_locked_i (pll_locked_i),
        .sh_mult      (sh_mult),
        .sh_div       (sh_div),
        .sh_en        (sh_en),
        .act_mult     (act_mult),
        .act_div      (act_div),
        .act_en       (act_en),
        .lock_q       (lock_q)
    );

    assign pll_mult_o = act_mult;
    assign pll_div_o  = act_div;
    assign pll_en_o   = act_en;

    always_comb begin
        bus_rdata = '0;
        if (bus_re) begin
            case (bus_addr)
                A_CFG: begin
                    bus_rdata[MULT_W-1:0]         = sh_mult;
                    bus_rdata[DIV_LSB +: DIV_W]   = sh_div;
                end
                A_CTRL: bus_rdata[0] = sh_en;
                A_STAT: begin
                    bus_rdata[MULT_W-1:0]         = act_mult;
                    bus_rdata[DIV_LSB +: DIV_W]   = act_div;
                    bus_rdata[EN_BIT]             = act_en;
                    bus_rdata[LOCK_BIT]           = lock_q;
                end
                A_OSC:  bus_rdata[0] = osc_ready_i;
                default: bus_rdata = '0;
            endcase
        end
    end

    // R9: reads without strobe stay quiet
    a_r9_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |-> (bus_rdata == '0));
endmodule

// File: tb/sim_pll_feed_regs.sv
module sim_pll_feed_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic        pll_locked_i = 1'b0;
    logic        osc_ready_i = 1'b0;
    logic [14:0] pll_mult_o;
    logic [7:0]  pll_div_o;
    logic        pll_en_o;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    pll_feed_regs u0 (.*);

    // vector: addr[58:56] data[55:24] exp_en[23] exp_div[22:15] exp_mult[14:0]
    localparam int NV = 17;
    localparam bit [58:0] VEC [NV] = '{
        {3'd0, 32'h0003_0010, 1'b0, 8'd0, 15'h000},  // R2 cfg pending
        {3'd1, 32'h0000_0001, 1'b0, 8'd0, 15'h000},  // R2 ctrl pending
        {3'd2, 32'h0000_00AA, 1'b0, 8'd0, 15'h000},  // arm
        {3'd2, 32'h0000_0055, 1'b1, 8'd3, 15'h010},  // R4 commit
        {3'd0, 32'h0001_0020, 1'b1, 8'd3, 15'h010},
        {3'd2, 32'h0000_00AA, 1'b1, 8'd3, 15'h010},
        {3'd1, 32'h0000_0001, 1'b1, 8'd3, 15'h010},  // R5 interrupt
        {3'd2, 32'h0000_0055, 1'b1, 8'd3, 15'h010},  // R5 no commit
        {3'd2, 32'h0000_00AA, 1'b1, 8'd3, 15'h010},
        {3'd2, 32'h0000_0012, 1'b1, 8'd3, 15'h010},  // R5 reject
        {3'd2, 32'h0000_0055, 1'b1, 8'd3, 15'h010},
        {3'd2, 32'h0000_00AA, 1'b1, 8'd3, 15'h010},
        {3'd2, 32'h0000_00AA, 1'b1, 8'd3, 15'h010},  // R6 rearm
        {3'd2, 32'h0000_0055, 1'b1, 8'd1, 15'h020},  // R6 commit
        {3'd1, 32'h0000_0000, 1'b1, 8'd1, 15'h020},
        {3'd2, 32'h0000_00AA, 1'b1, 8'd1, 15'h020},
        {3'd2, 32'h0000_0055, 1'b0, 8'd1, 15'h020}   // R4 disable commit
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a; bus_re = 1'b1;
        #1;
        d = bus_rdata;
        bus_re = 1'b0;
        #1;
    endtask

    function automatic logic [31:0] outs();
        return {8'd0, pll_en_o, pll_div_o, 1'b0, pll_mult_o};
    endfunction

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 outputs", outs(), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(3'd3, r); chk("R1 status", r, 32'h0);
        rd(3'd0, r); chk("R1 cfg", r, 32'h0);

        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][58:56], VEC[i][55:24]);
            chk("R2/R4/R5/R6 vector", outs(),
                {8'd0, VEC[i][23], VEC[i][22:15], 1'b0, VEC[i][14:0]});
        end

        // R2 pending readback differs from active
        wr(3'd0, 32'h0007_0044);
        rd(3'd0, r); chk("R2 cfg readback", r, 32'h0007_0044);
        wr(3'd1, 32'h0000_0001);
        rd(3'd1, r); chk("R2 ctrl readback", r, 32'h1);
        chk("R2 outputs held", outs(), {8'd0, 1'b0, 8'd1, 1'b0, 15'h020});

        // R5 lone 0x55
        wr(3'd2, 32'h55);
        chk("R5 lone second key", outs(), {8'd0, 1'b0, 8'd1, 1'b0, 15'h020});

        // R3 idle cycles and reads between keys
        wr(3'd2, 32'hAA);
        repeat (3) @(negedge clk);
        rd(3'd3, r);
        wr(3'd2, 32'h55);
        chk("R3 gap commit", outs(), {8'd0, 1'b1, 8'd7, 1'b0, 15'h044});

        // R3 upper bits must be zero
        wr(3'd0, 32'h0007_0045);
        wr(3'd2, 32'h1_00AA);
        wr(3'd2, 32'h55);
        chk("R3 exact key", outs(), {8'd0, 1'b1, 8'd7, 1'b0, 15'h044});

        // R7 lock with enable, and forced low without
        pll_locked_i = 1'b1;
        wr(3'd0, 32'h0007_0044);   // restore pending to active value
        @(negedge clk);
        rd(3'd3, r); chk("R7 lock set", r, 32'h0307_0044);
        // R8 ratio change drops lock for one cycle
        wr(3'd0, 32'h0002_0044);
        wr(3'd2, 32'hAA);
        wr(3'd2, 32'h55);
        rd(3'd3, r); chk("R8 lock cleared", r, 32'h0102_0044);
        @(negedge clk);
        rd(3'd3, r); chk("R8 lock returns", r, 32'h0302_0044);
        // R7 disable forces lock low
        wr(3'd1, 32'h0);
        wr(3'd2, 32'hAA);
        wr(3'd2, 32'h55);
        @(negedge clk);
        rd(3'd3, r); chk("R7 lock off when disabled", r, 32'h0002_0044);
        pll_locked_i = 1'b0;

        // R9 osc, key, unmapped, no strobe
        osc_ready_i = 1'b1;
        rd(3'd4, r); chk("R9 osc ready", r, 32'h1);
        osc_ready_i = 1'b0;
        rd(3'd4, r); chk("R9 osc low", r, 32'h0);
        rd(3'd2, r); chk("R9 key reads zero", r, 32'h0);
        rd(3'd6, r); chk("R9 unmapped", r, 32'h0);
        bus_addr = 3'd3; #1;
        chk("R9 no strobe", bus_rdata, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule